// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line in a small write-back cache that shares a snooping bus with other caches. Each line is Modified, Exclusive, Shared or Invalid. A processor sequencer serves one request at a time. It decides whether the request is a hit or a miss from the line's state and from a tag-compare result supplied from outside. On a miss or an upgrade it asks the bus for a read, a read-for-ownership, an invalidate or a write-back, and it finishes the request when the bus grants it. A line held only here and clean is Exclusive, so a later store completes without any bus traffic.

A snoop port carries transactions issued by other caches. The index on this port names a line whose resident tag already matches the snooped address. The block answers each snoop in the same cycle. It raises a shared indication for any valid copy, and when it holds the line Modified it supplies the dirty data in place of memory. It also lowers or drops the line's state. Snoops and the processor sequencer both update one bank of per-line state registers. The write on a line the sequencer is serving is kept consistent by three orderings: same-line acceptance is deferred, grants and snoops never share a cycle, and a pending upgrade or eviction re-checks the line's state.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid (state code 0; codes are I=0, S=1, E=2, M=3 in `line_state[2*i+1:2*i]`), `bus_req`, `cpu_done`, `snp_shared` and `snp_supply` are low, and `bus_cmd` is 0 whenever `bus_req` is low.
- R2: A read miss on an Invalid line is accepted with no bus request in its first cycle. From the next cycle it requests a read (`bus_cmd`=1). In the grant cycle `cpu_done` pulses and the line becomes Exclusive if `bus_shared_in` is low, or Shared if it is high.
- R3: A write hit on an Exclusive line pulses `cpu_done` in the cycle it is presented, makes the line Modified and raises no bus request.
- R4: A read hit on any valid line, and a write hit on a Modified line, pulse `cpu_done` in the cycle presented and leave the line unchanged with no bus request.
- R5: A write miss requests a read-for-ownership (`bus_cmd`=2), and in the grant cycle it pulses `cpu_done` and leaves the line Modified.
- R6: A write hit on a Shared line requests an invalidate (`bus_cmd`=3) from the next cycle, holds it until granted, and at the grant pulses `cpu_done` and makes the line Modified.
- R7: A snooped read (`snp_write`=0) of a Modified line raises `snp_supply` and `snp_shared` in that cycle, and the line becomes Shared.
- R8: A snooped read of an Exclusive or Shared line raises `snp_shared` without `snp_supply`, and the line ends Shared.
- R9: A snooped intent-to-write (`snp_write`=1) makes a Modified, Exclusive or Shared line Invalid. From Modified it also raises `snp_supply`, and it never raises `snp_shared`.
- R10: A snoop of an Invalid line raises neither response and changes no state.
- R11: A miss on a Modified line whose tag does not match first requests a write-back (`bus_cmd`=4). At that grant the line goes Invalid and the fill follows. A mismatching Exclusive or Shared line is dropped to Invalid with no write-back.
- R12: If a pending invalidate loses its Shared copy to a snooped intent-to-write, the invalidate is withdrawn and the store proceeds as a read-for-ownership.
- R13: If a pending write-back loses its Modified state to a snoop, the write-back is withdrawn and the fill proceeds without it.
- R14: A processor request is not accepted in a cycle in which a snoop names the same line. The snoop takes effect, and the request is served from the resulting state afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | Processor request present; held with its fields until `cpu_done` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_idx | input | IDXW | Line index of the request |
| cpu_tag_match | input | 1 | Resident tag of the indexed line equals the request's tag |
| cpu_done | output | 1 | Request completes in this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| bus_idx | output | IDXW | Line index of the requested transaction |
| bus_gnt | input | 1 | Requested transaction performed in this cycle |
| bus_shared_in | input | 1 | Another cache holds the line; sampled at a read grant |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_write | input | 1 | 1 = intent-to-write, 0 = read |
| snp_idx | input | IDXW | Line index the snoop hits |
| snp_shared | output | 1 | This cache keeps a copy after the snooped read |
| snp_supply | output | 1 | This cache supplies dirty data in place of memory |
| line_state | output | 2*LINES | State code of every line, two bits per line |

## Verification
A wrong state code shows on `line_state` at the next clock edge. It also changes the snoop answers in the cycle of the next snoop to that line: a missed `snp_supply` means memory would serve stale data, and a spurious `snp_shared` would keep a remote read out of Exclusive. A wrong sequencer state shows within one cycle as a wrong or missing `bus_cmd` or an early or missing `cpu_done`. The races with snoops matter most, because a lost update there leaves two writable copies. These are the upgrade overtaken by an invalidation, the eviction overtaken by an intervention and a same-line collision at acceptance.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_INV  = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_EVICT = 2'd1,
    SQ_FILL  = 2'd2,
    SQ_UPGR  = 2'd3
  } seq_st_e;

endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IDXW  = 2
) (
  input  logic                       snp_valid,
  input  logic                       snp_write,
  input  logic [IDXW-1:0]            snp_idx,
  input  logic [LINES-1:0][1:0]      st_cur,
  output logic [LINES-1:0]           snp_take,
  output logic [LINES-1:0][1:0]      snp_nxt,
  output logic                       snp_shared,
  output logic                       snp_supply
);

  logic [LINES-1:0] shr_vec;
  logic [LINES-1:0] sup_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit;
    always_comb begin
      hit         = snp_valid && (snp_idx == IDXW'(g)) && (line_st_e'(st_cur[g]) != LS_I);
      snp_take[g] = hit;
      snp_nxt[g]  = snp_write ? LS_I : LS_S;
      shr_vec[g]  = hit && !snp_write;
      sup_vec[g]  = hit && (line_st_e'(st_cur[g]) == LS_M);
    end
  end

  assign snp_shared = |shr_vec;
  assign snp_supply = |sup_vec;

endmodule

// File: rtl/mesi_req_seq.sv
module mesi_req_seq
  import mesi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpu_valid,
  input  logic     cpu_write,
  input  logic     cpu_tag_match,
  input  line_st_e sel_st,
  input  logic     collide,
  input  logic     bus_gnt,
  input  logic     bus_shared_in,
  output logic     upd_en,
  output line_st_e upd_st,
  output logic     bus_req,
  output bus_cmd_e bus_cmd,
  output logic     cpu_done
);

  seq_st_e seq_q, seq_d;
  logic    seq_en;
  logic    tag_hit;

  assign tag_hit = cpu_tag_match && (sel_st != LS_I);

  always_comb begin
    seq_d    = seq_q;
    upd_en   = 1'b0;
    upd_st   = LS_I;
    bus_req  = 1'b0;
    bus_cmd  = BC_NONE;
    cpu_done = 1'b0;
    unique case (seq_q)
      SQ_IDLE: begin
        if (cpu_valid && !collide) begin
          if (tag_hit) begin
            if (!cpu_write || sel_st == LS_M) begin
              cpu_done = 1'b1;
            end else if (sel_st == LS_E) begin
              upd_en   = 1'b1;
              upd_st   = LS_M;
              cpu_done = 1'b1;
            end else begin
              seq_d = SQ_UPGR;
            end
          end else if (sel_st == LS_M) begin
            seq_d = SQ_EVICT;
          end else begin
            upd_en = (sel_st != LS_I);
            upd_st = LS_I;
            seq_d  = SQ_FILL;
          end
        end
      end
      SQ_EVICT: begin
        if (sel_st == LS_M) begin
          bus_req = 1'b1;
          bus_cmd = BC_WB;
          if (bus_gnt) begin
            upd_en = 1'b1;
            upd_st = LS_I;
            seq_d  = SQ_FILL;
          end
        end else begin
          upd_en = 1'b1;
          upd_st = LS_I;
          seq_d  = SQ_FILL;
        end
      end
      SQ_FILL: begin
        bus_req = 1'b1;
        bus_cmd = cpu_write ? BC_RDX : BC_RD;
        if (bus_gnt) begin
          upd_en   = 1'b1;
          upd_st   = cpu_write ? LS_M : (bus_shared_in ? LS_S : LS_E);
          cpu_done = 1'b1;
          seq_d    = SQ_IDLE;
        end
      end
      SQ_UPGR: begin
        if (sel_st == LS_S) begin
          bus_req = 1'b1;
          bus_cmd = BC_INV;
          if (bus_gnt) begin
            upd_en   = 1'b1;
            upd_st   = LS_M;
            cpu_done = 1'b1;
            seq_d    = SQ_IDLE;
          end
        end else begin
          seq_d = SQ_FILL;
        end
      end
      default: seq_d = SQ_IDLE;
    endcase
  end

  assign seq_en = (seq_d != seq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;
    end else if (seq_en) begin
      seq_q <= seq_d;
    end
  end

endmodule

// File: rtl/mesi_state_bank.sv
module mesi_state_bank
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IDXW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  logic [IDXW-1:0]       upd_idx,
  input  line_st_e              upd_st,
  input  logic [LINES-1:0]      snp_take,
  input  logic [LINES-1:0][1:0] snp_nxt,
  output logic [LINES-1:0][1:0] st_q
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e q;
    line_st_e d;
    logic     ld;
    logic     own;

    always_comb begin
      own = upd_en && (upd_idx == IDXW'(g));
      ld  = own || snp_take[g];
      d   = own ? upd_st : line_st_e'(snp_nxt[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= LS_I;
      end else if (ld) begin
        q <= d;
      end
    end

    assign st_q[g] = q;
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_valid,
  input  logic                 cpu_write,
  input  logic [IDXW-1:0]      cpu_idx,
  input  logic                 cpu_tag_match,
  output logic                 cpu_done,
  output logic                 bus_req,
  output logic [2:0]           bus_cmd,
  output logic [IDXW-1:0]      bus_idx,
  input  logic                 bus_gnt,
  input  logic                 bus_shared_in,
  input  logic                 snp_valid,
  input  logic                 snp_write,
  input  logic [IDXW-1:0]      snp_idx,
  output logic                 snp_shared,
  output logic                 snp_supply,
  output logic [2*LINES-1:0]   line_state
);

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic [LINES-1:0][1:0] st_q;
  logic [LINES-1:0]      snp_take;
  logic [LINES-1:0][1:0] snp_nxt;
  logic                  upd_en;
  line_st_e              upd_st;
  line_st_e              sel_st;
  logic                  collide;
  bus_cmd_e              cmd_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel_st  = line_st_e'(st_q[cpu_idx]);
  assign collide = snp_valid && (snp_idx == cpu_idx);

  mesi_snoop_resp #(.LINES(LINES), .IDXW(IDXW)) snoop_i (
    .snp_valid  (snp_valid),
    .snp_write  (snp_write),
    .snp_idx    (snp_idx),
    .st_cur     (st_q),
    .snp_take   (snp_take),
    .snp_nxt    (snp_nxt),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply)
  );

  mesi_req_seq seq_i (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cpu_valid     (cpu_valid),
    .cpu_write     (cpu_write),
    .cpu_tag_match (cpu_tag_match),
    .sel_st        (sel_st),
    .collide       (collide),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .upd_en        (upd_en),
    .upd_st        (upd_st),
    .bus_req       (bus_req),
    .bus_cmd       (cmd_e),
    .cpu_done      (cpu_done)
  );

  mesi_state_bank #(.LINES(LINES), .IDXW(IDXW)) bank_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_en   (upd_en),
    .upd_idx  (cpu_idx),
    .upd_st   (upd_st),
    .snp_take (snp_take),
    .snp_nxt  (snp_nxt),
    .st_q     (st_q)
  );

  assign bus_cmd    = cmd_e;
  assign bus_idx    = cpu_idx;
  assign line_state = st_q;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int LINES = 4,
  parameter int IDXW  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_write,
  input logic [IDXW-1:0]    cpu_idx,
  input logic               cpu_done,
  input logic               bus_req,
  input logic [2:0]         bus_cmd,
  input logic [IDXW-1:0]    bus_idx,
  input logic               snp_valid,
  input logic               snp_write,
  input logic [IDXW-1:0]    snp_idx,
  input logic               snp_shared,
  input logic               snp_supply,
  input logic [2*LINES-1:0] line_state
);

  function automatic logic [1:0] st_at(input logic [2*LINES-1:0] v, input logic [IDXW-1:0] i);
    return v[2*i +: 2];
  endfunction

  // R7
  remote_read_of_dirty_supplies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_write && st_at(line_state, snp_idx) == 2'd3) |-> (snp_supply && snp_shared));

  // R9
  remote_write_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_write) |=> (st_at(line_state, $past(snp_idx)) == 2'd0));

  // R10
  invalid_line_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && st_at(line_state, snp_idx) == 2'd0) |-> (!snp_shared && !snp_supply));

  // R6
  invalidate_only_from_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 3'd3) |-> (st_at(line_state, bus_idx) == 2'd1));

  // R11
  writeback_only_from_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 3'd4) |-> (st_at(line_state, bus_idx) == 2'd3));

  // R5
  store_ends_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_write) |=> (st_at(line_state, $past(cpu_idx)) == 2'd3));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.LINES(LINES), .IDXW(IDXW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_write  (cpu_write),
  .cpu_idx    (cpu_idx),
  .cpu_done   (cpu_done),
  .bus_req    (bus_req),
  .bus_cmd    (bus_cmd),
  .bus_idx    (bus_idx),
  .snp_valid  (snp_valid),
  .snp_write  (snp_write),
  .snp_idx    (snp_idx),
  .snp_shared (snp_shared),
  .snp_supply (snp_supply),
  .line_state (line_state)
);

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;

  localparam int LINES = 4;
  localparam int IDXW  = 2;

  logic             clk;
  logic             rst_n;
  logic             cpu_valid, cpu_write, cpu_tag_match;
  logic [IDXW-1:0]  cpu_idx;
  logic             cpu_done;
  logic             bus_req;
  logic [2:0]       bus_cmd;
  logic [IDXW-1:0]  bus_idx;
  logic             bus_gnt, bus_shared_in;
  logic             snp_valid, snp_write;
  logic [IDXW-1:0]  snp_idx;
  logic             snp_shared, snp_supply;
  logic [2*LINES-1:0] line_state;

  int n_cmp;
  int n_bad;
  int mst[LINES];
  int mseq;

  mesi_line_ctrl #(.LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_idx(cpu_idx),
    .cpu_tag_match(cpu_tag_match), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_idx(snp_idx),
    .snp_shared(snp_shared), .snp_supply(snp_supply),
    .line_state(line_state)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive, compare against the reference, advance the reference.
  task automatic step(bit v, bit w, int idx, bit tm, bit g, bit sh,
                      bit sv, bit sw, int sidx, string tag);
    int  nst[LINES];
    int  nseq;
    int  cur;
    int  e_cmd;
    int  packed_st;
    bit  e_req, e_done, e_shr, e_sup, coll;
    cpu_valid = v; cpu_write = w; cpu_idx = IDXW'(idx); cpu_tag_match = tm;
    bus_gnt = g; bus_shared_in = sh;
    snp_valid = sv; snp_write = sw; snp_idx = IDXW'(sidx);
    #1;
    nst = mst; nseq = mseq;
    e_req = 0; e_cmd = 0; e_done = 0; e_shr = 0; e_sup = 0;
    if (sv && mst[sidx] != 0) begin
      e_shr = !sw;
      e_sup = (mst[sidx] == 3);
      nst[sidx] = sw ? 0 : 1;
    end
    cur  = mst[idx];
    coll = sv && (sidx == idx);
    if (mseq == 0) begin
      if (v && !coll) begin
        if (tm && cur != 0) begin
          if (!w || cur == 3) e_done = 1;
          else if (cur == 2) begin nst[idx] = 3; e_done = 1; end
          else nseq = 3;
        end else if (cur == 3) nseq = 1;
        else begin nst[idx] = 0; nseq = 2; end
      end
    end else if (mseq == 1) begin
      if (cur == 3) begin
        e_req = 1; e_cmd = 4;
        if (g) begin nst[idx] = 0; nseq = 2; end
      end else begin nst[idx] = 0; nseq = 2; end
    end else if (mseq == 2) begin
      e_req = 1; e_cmd = w ? 2 : 1;
      if (g) begin nst[idx] = w ? 3 : (sh ? 1 : 2); e_done = 1; nseq = 0; end
    end else begin
      if (cur == 1) begin
        e_req = 1; e_cmd = 3;
        if (g) begin nst[idx] = 3; e_done = 1; nseq = 0; end
      end else nseq = 2;
    end
    packed_st = 0;
    for (int i = 0; i < LINES; i++) packed_st |= (mst[i] << (2*i));
    chk(tag, "line_state", int'(line_state), packed_st);
    chk(tag, "bus_req", int'(bus_req), int'(e_req));
    chk(tag, "bus_cmd", int'(bus_cmd), e_cmd);
    if (e_req) chk(tag, "bus_idx", int'(bus_idx), idx);
    chk(tag, "cpu_done", int'(cpu_done), int'(e_done));
    chk(tag, "snp_shared", int'(snp_shared), int'(e_shr));
    chk(tag, "snp_supply", int'(snp_supply), int'(e_sup));
    @(posedge clk);
    mst = nst; mseq = nseq;
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; mseq = 0;
    for (int i = 0; i < LINES; i++) mst[i] = 0;
    rst_n = 0;
    cpu_valid = 0; cpu_write = 0; cpu_idx = '0; cpu_tag_match = 0;
    bus_gnt = 0; bus_shared_in = 0; snp_valid = 0; snp_write = 0; snp_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) idle("R1");

    // R2: read miss, not shared elsewhere -> E
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 1, 0, 0, 0, 0, "R2");
    idle("R2");
    // R4: read hit on E
    step(1, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
    // R3: write hit on E
    step(1, 1, 0, 1, 0, 0, 0, 0, 0, "R3");
    idle("R3");
    // R4: hits on M
    step(1, 1, 0, 1, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
    // R7: remote read of M
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    idle("R7");
    // R8: remote read of S
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    idle("R8");
    // R6: write hit on S, grant held off one cycle
    step(1, 1, 0, 1, 0, 0, 0, 0, 0, "R6");
    step(1, 1, 0, 1, 0, 0, 0, 0, 0, "R6");
    step(1, 1, 0, 1, 1, 0, 0, 0, 0, "R6");
    idle("R6");
    // R9: remote intent-to-write on M
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R9");
    idle("R9");
    // R10: snoops on invalid lines
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, "R10");
    idle("R10");
    // R2: read miss with shared copy elsewhere -> S
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 1, 0, 1, 1, 0, 0, 0, "R2");
    idle("R2");
    // R9: intent-to-write on S, no supply
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, "R9");
    idle("R9");
    // R5: write miss
    step(1, 1, 2, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 1, 2, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 1, 2, 0, 1, 0, 0, 0, 0, "R5");
    idle("R5");
    // R11: conflict miss on M -> write-back then fill
    step(1, 0, 2, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 0, 2, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 0, 2, 0, 1, 0, 0, 0, 0, "R11");
    step(1, 0, 2, 0, 1, 0, 0, 0, 0, "R11");
    idle("R11");
    // R11: conflict miss on E -> silent drop
    step(1, 0, 2, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 0, 2, 0, 1, 0, 0, 0, 0, "R11");
    idle("R11");
    // R8: remote read of E
    step(0, 0, 0, 0, 0, 0, 1, 0, 2, "R8");
    idle("R8");
    // R12: upgrade overtaken by remote intent-to-write
    step(1, 0, 3, 0, 0, 0, 0, 0, 0, "R12");
    step(1, 0, 3, 0, 1, 1, 0, 0, 0, "R12");
    idle("R12");
    step(1, 1, 3, 1, 0, 0, 0, 0, 0, "R12");
    step(1, 1, 3, 1, 0, 0, 1, 1, 3, "R12");
    step(1, 1, 3, 1, 0, 0, 0, 0, 0, "R12");
    step(1, 1, 3, 1, 1, 0, 0, 0, 0, "R12");
    idle("R12");
    // R13: eviction overtaken by remote read
    step(1, 0, 3, 0, 0, 0, 0, 0, 0, "R13");
    step(1, 0, 3, 0, 0, 0, 1, 0, 3, "R13");
    step(1, 0, 3, 0, 0, 0, 0, 0, 0, "R13");
    step(1, 0, 3, 0, 1, 1, 0, 0, 0, "R13");
    idle("R13");
    // R14: same-line snoop defers acceptance
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R14");
    step(1, 0, 1, 0, 1, 0, 0, 0, 0, "R14");
    idle("R14");
    step(1, 1, 1, 1, 0, 0, 1, 0, 1, "R14");
    step(1, 1, 1, 1, 0, 0, 0, 0, 0, "R14");
    step(1, 1, 1, 1, 1, 0, 0, 0, 0, "R14");
    idle("R14");
    idle("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule